// File: doc/BRIEF.md
# Timer Interrupt Status and Line Router

This block sits behind a bank of timer channels and turns their fire events into interrupt lines. Each channel is either level type or edge type. A level-type fire latches a pending status bit and holds the channel's line high until software clears the bit. An edge-type fire produces a one-cycle pulse and leaves no status behind. A line is only driven while both the channel's own enable and the global enable are set. Status is recorded regardless of either enable, so a pending level event shows up on its line as soon as both enables become true.

Every channel carries a route field that picks one of the interrupt lines. Several channels may share a line, and their requests are ORed. In legacy mode, channel 0 and channel 1 ignore their route fields and go to fixed lines 0 and 8. The two legacy sources, a periodic tick and a real-time-clock line, are then masked, and the legacy-timer enable output drops. Outside legacy mode the two legacy sources pass through, each delayed by one register, onto lines 0 and 8. The clock line level is sampled at all times, so line 8 shows the current level again at once when legacy mode ends.

Top module: `tirq_hub`

## Requirements
- R1: At the clock edge where a level-type channel (level bit = 1) fires, its status bit is set. An edge-type fire (level bit = 0) leaves the status bit clear.
- R2: A channel drives its line only while its enable and the global enable are both 1. A level-type channel holds the line high while its status is set. An edge-type channel raises the line for exactly the one cycle after the edge that captured the fire.
- R3: A status-clear write (write strobe high) with a 1 in bit i clears status bit i at the next edge, and the line then drops. Bits written as 0 leave their status unchanged. If a level fire arrives in the same cycle as a clear of that bit, the fire wins and the bit stays set.
- R4: Status is kept while the channel enable or the global enable is 0. When either enable is raised while status is pending, the line comes up in the same cycle. When the global enable is cleared, all channel lines drop, but status is kept.
- R5: When a channel changes from level to edge type, its line drops in the same cycle and its status is cleared at the next edge.
- R6: The route field is 5 bits per channel, with channel c at bits [5c+4:5c] of the route bus. It selects line 0 to 31. Lines shared by several channels carry the OR of their requests.
- R7: In legacy mode, channel 0 drives line 0 and channel 1 drives line 8, whatever their route fields hold.
- R8: In legacy mode the legacy-timer enable output is 0, and the tick and clock inputs do not reach lines 0 and 8. Outside legacy mode the enable output is 1.
- R9: Outside legacy mode, line 0 follows the tick input and line 8 follows the clock input, each one cycle later. The clock level is registered in all modes, so line 8 shows the current level at once when legacy mode ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fire_i | input | NCH | One bit per channel; high for each cycle in which the channel fires |
| ch_en_i | input | NCH | Per-channel interrupt enable |
| ch_level_i | input | NCH | Per-channel type: 1 = level, 0 = edge |
| ch_route_i | input | NCH*RW | Per-channel line select, RW bits each, channel 0 in the low bits |
| glb_en_i | input | 1 | Global interrupt enable |
| legacy_i | input | 1 | Legacy routing mode |
| clr_we_i | input | 1 | Status-clear write strobe |
| clr_data_i | input | NCH | Status-clear mask; 1 clears the bit |
| pit_tick_i | input | 1 | Legacy periodic tick source |
| rtc_irq_i | input | 1 | Legacy real-time-clock interrupt level |
| irq_o | output | NLINES | Interrupt lines |
| pit_en_o | output | 1 | Legacy timer enable, low in legacy mode |

## Verification
The assertions assume that every input is synchronous to the clock and stays stable around its rising edge. They also assume that a channel's type bit in the cycle of a fire is the type that fire should be judged by. The route fields are assumed to lie within the line count, and for legacy routing there are at least two channels and more than eight lines. The bench changes inputs only on the falling edge, keeps the default geometry of 8 channels and 32 lines, and returns every status bit to clear before the next pattern starts.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
  // fixed lines used by legacy routing and legacy pass-through
  localparam int unsigned LEG_LINE_TICK = 0;
  localparam int unsigned LEG_LINE_CLK  = 8;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/tirq_status.sv
module tirq_status #(
  parameter int unsigned NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] fire_i,
  input  logic [NCH-1:0] ch_en_i,
  input  logic [NCH-1:0] ch_level_i,
  input  logic           glb_en_i,
  input  logic           clr_we_i,
  input  logic [NCH-1:0] clr_data_i,
  output logic [NCH-1:0] act_o
);
  import tirq_pkg::*;

  logic [NCH-1:0] status_q, status_d;
  logic [NCH-1:0] pulse_q, pulse_d;
  logic [NCH-1:0] clr_hit;

  assign clr_hit = clr_we_i ? clr_data_i : '0;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      if (trig_e'(ch_level_i[c]) == TRIG_LEVEL) begin
        // a fresh fire takes priority over a clear in the same cycle
        status_d[c] = fire_i[c] | (status_q[c] & ~clr_hit[c]);
        pulse_d[c]  = 1'b0;
      end else begin
        // edge type never holds status; leaving level type drops it
        status_d[c] = 1'b0;
        pulse_d[c]  = fire_i[c] & ch_en_i[c] & glb_en_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      pulse_q  <= '0;
    end else begin
      status_q <= status_d;
      pulse_q  <= pulse_d;
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      if (trig_e'(ch_level_i[c]) == TRIG_LEVEL)
        act_o[c] = status_q[c] & ch_en_i[c] & glb_en_i;
      else
        act_o[c] = pulse_q[c] & ch_en_i[c] & glb_en_i;
    end
  end

  AST_GLB_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en_i |-> (act_o == '0)); // R4

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    AST_LEVEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_i[c] && ch_level_i[c]) |=> status_q[c]); // R1
    AST_EDGE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_i[c] && !ch_level_i[c]) |=> !status_q[c]); // R1
    AST_CLR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[c] && clr_we_i && clr_data_i[c] && !fire_i[c]) |=> !status_q[c]); // R3
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[c] && ch_level_i[c] && !(clr_we_i && clr_data_i[c])) |=> status_q[c]); // R3
    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_q[c] && !fire_i[c]) |=> !pulse_q[c]); // R2
  end
endmodule

// File: rtl/tirq_route.sv
module tirq_route #(
  parameter int unsigned NCH    = 8,
  parameter int unsigned NLINES = 32,
  parameter int unsigned RW     = $clog2(NLINES)
) (
  input  logic [NCH-1:0]    act_i,
  input  logic [NCH*RW-1:0] ch_route_i,
  input  logic              legacy_i,
  output logic [NLINES-1:0] lines_o
);
  import tirq_pkg::*;

  logic [RW-1:0]     dest [NCH];
  logic [NLINES-1:0] sel  [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_dest
    if (c == 0) begin : g_fix0
      always_comb
        dest[c] = legacy_i ? RW'(LEG_LINE_TICK) : ch_route_i[c*RW +: RW];
    end else if (c == 1) begin : g_fix1
      always_comb
        dest[c] = legacy_i ? RW'(LEG_LINE_CLK) : ch_route_i[c*RW +: RW];
    end else begin : g_free
      always_comb dest[c] = ch_route_i[c*RW +: RW];
    end
    always_comb
      sel[c] = act_i[c] ? (NLINES'(1) << dest[c]) : '0;
  end

  always_comb begin
    lines_o = '0;
    for (int c = 0; c < NCH; c++) lines_o = lines_o | sel[c];
  end
endmodule

// File: rtl/tirq_legacy.sv
module tirq_legacy #(
  parameter int unsigned NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pit_tick_i,
  input  logic              rtc_irq_i,
  input  logic              legacy_i,
  output logic [NLINES-1:0] lines_o,
  output logic              pit_en_o
);
  import tirq_pkg::*;

  logic tick_q, tick_d;
  logic clk_lvl_q, clk_lvl_d;

  // the clock level is captured in every mode
  always_comb begin
    tick_d    = pit_tick_i;
    clk_lvl_d = rtc_irq_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q    <= 1'b0;
      clk_lvl_q <= 1'b0;
    end else begin
      tick_q    <= tick_d;
      clk_lvl_q <= clk_lvl_d;
    end
  end

  always_comb begin
    lines_o = '0;
    if (!legacy_i) begin
      lines_o[LEG_LINE_TICK] = tick_q;
      lines_o[LEG_LINE_CLK]  = clk_lvl_q;
    end
  end

  assign pit_en_o = ~legacy_i;
endmodule

// File: rtl/tirq_hub.sv
module tirq_hub #(
  parameter int unsigned NCH    = 8,
  parameter int unsigned NLINES = 32,
  parameter int unsigned RW     = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    fire_i,
  input  logic [NCH-1:0]    ch_en_i,
  input  logic [NCH-1:0]    ch_level_i,
  input  logic [NCH*RW-1:0] ch_route_i,
  input  logic              glb_en_i,
  input  logic              legacy_i,
  input  logic              clr_we_i,
  input  logic [NCH-1:0]    clr_data_i,
  input  logic              pit_tick_i,
  input  logic              rtc_irq_i,
  output logic [NLINES-1:0] irq_o,
  output logic              pit_en_o
);
  import tirq_pkg::*;

  logic [NCH-1:0]    ch_act;
  logic [NLINES-1:0] ch_lines;
  logic [NLINES-1:0] leg_lines;

  tirq_status #(.NCH(NCH)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire_i     (fire_i),
    .ch_en_i    (ch_en_i),
    .ch_level_i (ch_level_i),
    .glb_en_i   (glb_en_i),
    .clr_we_i   (clr_we_i),
    .clr_data_i (clr_data_i),
    .act_o      (ch_act)
  );

  tirq_route #(.NCH(NCH), .NLINES(NLINES), .RW(RW)) u_route (
    .act_i      (ch_act),
    .ch_route_i (ch_route_i),
    .legacy_i   (legacy_i),
    .lines_o    (ch_lines)
  );

  tirq_legacy #(.NLINES(NLINES)) u_legacy (
    .clk        (clk),
    .rst_n      (rst_n),
    .pit_tick_i (pit_tick_i),
    .rtc_irq_i  (rtc_irq_i),
    .legacy_i   (legacy_i),
    .lines_o    (leg_lines),
    .pit_en_o   (pit_en_o)
  );

  assign irq_o = ch_lines | leg_lines;

  AST_LEG_CH0: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy_i && ch_act[0]) |-> irq_o[LEG_LINE_TICK]); // R7
  AST_LEG_CH1: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy_i && ch_act[1]) |-> irq_o[LEG_LINE_CLK]); // R7
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy_i && ch_act == '0) |-> (irq_o == '0)); // R8
endmodule

// File: tb/sim_tirq_hub.sv
`timescale 1ns/1ps
module sim_tirq_hub;
  localparam int NCH = 8;
  localparam int NL  = 32;
  localparam int RW  = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0]    fire, en, lvl, clr_data;
  logic [NCH*RW-1:0] route;
  logic glb, leg, clr_we, pit, rtc;
  logic [NL-1:0] irq;
  logic pit_en;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tirq_hub #(.NCH(NCH), .NLINES(NL), .RW(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .fire_i(fire), .ch_en_i(en), .ch_level_i(lvl),
    .ch_route_i(route), .glb_en_i(glb), .legacy_i(leg), .clr_we_i(clr_we),
    .clr_data_i(clr_data), .pit_tick_i(pit), .rtc_irq_i(rtc),
    .irq_o(irq), .pit_en_o(pit_en)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fire_ch(int c);
    fire[c] = 1'b1;
    tick();
    fire = '0;
    #0.5;
  endtask

  task automatic clear(logic [NCH-1:0] m);
    clr_we = 1'b1;
    clr_data = m;
    tick();
    clr_we = 1'b0;
    clr_data = '0;
    #0.5;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    fire = '0; en = '0; lvl = '0; clr_data = '0; route = '0;
    glb = 1'b1; leg = 1'b0; clr_we = 1'b0; pit = 1'b0; rtc = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset irq", irq, 32'h0);
    check("reset R8 pit_en", {31'd0, pit_en}, 32'h1);

    // R1 R6 R3: sweep every channel over every route, level type
    for (int c = 0; c < NCH; c++) begin
      for (int r = 0; r < NL; r++) begin
        route = '0;
        route[c*RW +: RW] = RW'(r);
        en = NCH'(1) << c;
        lvl = NCH'(1) << c;
        fire_ch(c);
        check($sformatf("R1 R6 ch%0d route%0d", c, r), irq, 32'h1 << r);
        clear(NCH'(1) << c);
        check($sformatf("R3 clear ch%0d", c), irq, 32'h0);
      end
    end

    // R2 R1: edge type, pulse for one cycle, no status left
    for (int c = 0; c < NCH; c++) begin
      route = '0;
      route[c*RW +: RW] = RW'(c + 20);
      en = NCH'(1) << c;
      lvl = '0;
      fire_ch(c);
      check($sformatf("R2 edge pulse ch%0d", c), irq, 32'h1 << (c + 20));
      tick();
      check($sformatf("R2 edge end ch%0d", c), irq, 32'h0);
      lvl = NCH'(1) << c;
      #0.5;
      check($sformatf("R1 edge no status ch%0d", c), irq, 32'h0);
      lvl = '0;
    end

    // R2 R4: level fire while channel disabled, then enable
    route = '0;
    route[2*RW +: RW] = 5'd5;
    lvl = 8'h04; en = 8'h00;
    fire_ch(2);
    check("R2 disabled no line", irq, 32'h0);
    en = 8'h04; #0.5;
    check("R4 enable reasserts", irq, 32'h1 << 5);
    glb = 1'b0; #0.5;
    check("R4 global off lowers", irq, 32'h0);
    tick();
    check("R4 global off keeps low", irq, 32'h0);
    glb = 1'b1; #0.5;
    check("R4 global on reasserts", irq, 32'h1 << 5);

    // R3: zeros in the write leave status, ones on clear bits do nothing
    clear(8'hFB);
    check("R3 zero write ignored", irq, 32'h1 << 5);
    // R3: fire and clear same cycle, fire wins
    fire[2] = 1'b1; clr_we = 1'b1; clr_data = 8'h04;
    tick();
    fire = '0; clr_we = 1'b0; clr_data = '0; #0.5;
    check("R3 set wins over clear", irq, 32'h1 << 5);

    // R5: level to edge drops line at once and clears status
    lvl = 8'h00; #0.5;
    check("R5 line drops", irq, 32'h0);
    tick();
    lvl = 8'h04; #0.5;
    check("R5 status cleared", irq, 32'h0);

    // R6: two channels share a line
    route = '0;
    route[3*RW +: RW] = 5'd17;
    route[4*RW +: RW] = 5'd17;
    en = 8'h18; lvl = 8'h18;
    fire_ch(3);
    fire_ch(4);
    clear(8'h08);
    check("R6 shared line held", irq, 32'h1 << 17);
    clear(8'h10);
    check("R6 shared line released", irq, 32'h0);

    // R7: legacy forces channels 0 and 1
    leg = 1'b1;
    route = '0;
    route[0 +: RW] = 5'd3;
    route[RW +: RW] = 5'd3;
    en = 8'h03; lvl = 8'h03;
    fire_ch(0);
    check("R7 ch0 to line0", irq, 32'h1);
    clear(8'h01);
    fire_ch(1);
    check("R7 ch1 to line8", irq, 32'h1 << 8);
    clear(8'h02);
    check("R8 pit_en low", {31'd0, pit_en}, 32'h0);

    // R8: legacy inputs masked
    en = '0;
    pit = 1'b1; rtc = 1'b1;
    tick();
    check("R8 sources masked", irq, 32'h0);
    // R9: leaving legacy restores line 8 at once, tick on line 0
    leg = 1'b0; #0.5;
    check("R9 restore line8 and tick", irq, 32'h101);
    check("R8 pit_en high", {31'd0, pit_en}, 32'h1);
    pit = 1'b0; rtc = 1'b0; #0.5;
    check("R9 one cycle delay", irq, 32'h101);
    tick();
    check("R9 sources low", irq, 32'h0);
    pit = 1'b1;
    tick();
    pit = 1'b0;
    check("R9 tick pass", irq, 32'h1);
    tick();
    check("R9 tick end", irq, 32'h0);

    finish_run();
  end
endmodule